// File: doc/BRIEF.md
# Command-Phase Register Port for a USB Device Controller

This block sits between a 16-bit processor bus and the control registers of a USB device-controller core. Software first writes a one-byte command code. The code selects a target register, a transfer direction and a fixed number of 16-bit data words. The block then accepts exactly that many data writes or data reads. Each data access goes to the selected register: the endpoint configuration bytes, the per-endpoint error codes, a scratch word, the frame number, a chip identifier, the 32-bit interrupt word, or an unlock word that is handed on to the core.

The word count comes from the byte width of the target as (N+1)/2. One-byte and two-byte targets therefore take one word, and the interrupt word takes two. Codes with no data phase complete when the command is written. Unknown codes raise an error flag. Once the last data word is accepted, the block returns to waiting for a command. A command written in the middle of a data phase replaces the transfer that is pending.

Top module: `cmd_regif`

## Requirements
- R1: During and after reset, words_left is 0, rdata is 0, cmd_err, ack_setup and unlock_pulse are 0, and every endpoint configuration byte on ep_cfg is 0.
- R2: Command 0x20+n (n = 0 for control OUT, 1 for control IN, 2 to 15 for endpoints 1 to 14) followed by one data write stores wdata[7:0] in configuration byte n. That byte sits at ep_cfg[8n+7:8n] from the next cycle, and wdata[15:8] is discarded.
- R3: Command 0x30+n followed by a read returns configuration byte n in rdata[7:0], with rdata[15:8] equal to 0.
- R4: Command 0xA0+n returns error code n, taken from ep_err_codes[8n+7:8n], in rdata[7:0] with the upper byte 0, over one read word.
- R5: Command 0xB2 with one data write loads the 16-bit scratch word. Command 0xB3 reads all 16 bits back in one word.
- R6: Command 0xB4 returns frame_num zero-extended to 16 bits. Command 0xB5 returns the CHIP_ID parameter. Each uses one read word.
- R7: Command 0xC0 takes two read words: bits 15:0 of irq_status first, then bits 31:16. Reading has no side effect, so repeating the command returns the same words while irq_status is unchanged.
- R8: Command 0xF4 has no data phase. ack_setup pulses for exactly one cycle after the command, and words_left stays 0.
- R9: Command 0xB0 followed by one data write pulses unlock_pulse for one cycle, with unlock_data equal to the written word.
- R10: An unknown command code sets cmd_err from the next cycle until the next command, and opens no data phase. Data strobes that follow it change no output.
- R11: After a command, words_left equals the word count of the code and falls by one for each accepted strobe. At 0 the block is idle, rdata is 0, and further strobes change nothing.
- R12: A strobe in the wrong direction for the pending command (data_wr during a read, data_rd during a write) is ignored and does not change words_left.
- R13: A command written while words remain drops the pending transfer and starts the new one. When cmd_wr and a data strobe come in the same cycle, the command takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command strobe; code on wdata[7:0] |
| data_wr | input | 1 | Data write strobe |
| data_rd | input | 1 | Data read strobe; the word is taken from rdata in this cycle |
| wdata | input | 16 | Command code or write data |
| rdata | output | 16 | Current read word; 0 when no read is pending |
| words_left | output | 2 | Data words still expected |
| cmd_err | output | 1 | Last command code was unknown |
| ack_setup | output | 1 | One-cycle pulse after command 0xF4 |
| unlock_pulse | output | 1 | One-cycle pulse after the unlock word is written |
| unlock_data | output | 16 | Word written with the unlock command |
| ep_err_codes | input | 128 | Error code per endpoint, 8 bits each |
| frame_num | input | 11 | Current frame number |
| irq_status | input | 32 | Interrupt word from the core |
| ep_cfg | output | 128 | Configuration byte per endpoint |

## Verification
The bench uses 16-word apart code pairs on the same endpoint to catch a design that splits read and write banks at the wrong bit, because such a design would write one endpoint and read back another. It writes configuration data with a nonzero upper byte, so a design that passes 16 bits through to an 8-bit register shows a nonzero upper byte on readback. It sends extra, wrong-direction and same-cycle strobes. A countdown that underflows, or one that accepts the wrong direction, would then produce stray writes or a second unlock pulse. It cuts the interrupt transfer short with a new command, because a design that kept the stale count would return the upper half or accept a write too many.

// File: rtl/cmd_regif.sv
module cmd_regif #(
  parameter int          NUM_EP  = 16,
  parameter int          CFG_W   = 8,
  parameter int          ERR_W   = 8,
  parameter int          FRM_W   = 11,
  parameter int          IRQ_W   = 32,
  parameter logic [15:0] CHIP_ID = 16'h5A31
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_wr,
  input  logic                    data_wr,
  input  logic                    data_rd,
  input  logic [15:0]             wdata,
  output logic [15:0]             rdata,
  output logic [1:0]              words_left,
  output logic                    cmd_err,
  output logic                    ack_setup,
  output logic                    unlock_pulse,
  output logic [15:0]             unlock_data,
  input  logic [NUM_EP*ERR_W-1:0] ep_err_codes,
  input  logic [FRM_W-1:0]        frame_num,
  input  logic [IRQ_W-1:0]        irq_status,
  output logic [NUM_EP*CFG_W-1:0] ep_cfg
);
  localparam int IDX_W = $clog2(NUM_EP);

  function automatic logic [1:0] words_for(input int nbytes);
    return 2'((nbytes + 1) / 2);
  endfunction

  localparam logic [1:0] W_CFG = words_for((CFG_W + 7) / 8);
  localparam logic [1:0] W_ERR = words_for((ERR_W + 7) / 8);
  localparam logic [1:0] W_FRM = words_for((FRM_W + 7) / 8);
  localparam logic [1:0] W_REG = words_for(2);
  localparam logic [1:0] W_IRQ = words_for(IRQ_W / 8);

  logic [7:0]  code, cmd_q;
  logic        rd_q, known, is_rd, ep_ok, wr_ok, rd_ok;
  logic [1:0]  nw, left_q;
  logic [15:0] scratch_q;
  logic [CFG_W-1:0] cfg_q [NUM_EP];
  logic [IDX_W-1:0] idx;

  assign code  = wdata[7:0];
  assign ep_ok = (int'(code[3:0]) < NUM_EP);
  assign idx   = cmd_q[IDX_W-1:0];
  assign wr_ok = data_wr && !cmd_wr && (left_q != 2'd0) && !rd_q;
  assign rd_ok = data_rd && !cmd_wr && (left_q != 2'd0) && rd_q;
  assign words_left = left_q;

  always_comb begin
    known = 1'b1;
    is_rd = 1'b1;
    nw    = 2'd0;
    casez (code)
      8'h2?:        begin is_rd = 1'b0; nw = W_CFG; known = ep_ok; end
      8'h3?:        begin nw = W_CFG; known = ep_ok; end
      8'hA?:        begin nw = W_ERR; known = ep_ok; end
      8'hB0, 8'hB2: begin is_rd = 1'b0; nw = W_REG; end
      8'hB3, 8'hB5: nw = W_REG;
      8'hB4:        nw = W_FRM;
      8'hC0:        nw = W_IRQ;
      8'hF4:        nw = 2'd0;
      default:      known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q        <= 8'h00;
      rd_q         <= 1'b0;
      left_q       <= 2'd0;
      cmd_err      <= 1'b0;
      ack_setup    <= 1'b0;
      unlock_pulse <= 1'b0;
      unlock_data  <= 16'h0000;
      scratch_q    <= 16'h0000;
    end else begin
      ack_setup    <= cmd_wr && (code == 8'hF4);
      unlock_pulse <= 1'b0;
      if (cmd_wr) begin
        cmd_q   <= code;
        rd_q    <= is_rd;
        left_q  <= known ? nw : 2'd0;
        cmd_err <= !known;
      end else if (wr_ok || rd_ok) begin
        left_q <= left_q - 2'd1;
      end
      if (wr_ok && cmd_q == 8'hB0) begin
        unlock_pulse <= 1'b1;
        unlock_data  <= wdata;
      end
      if (wr_ok && cmd_q == 8'hB2) scratch_q <= wdata;
    end
  end

  for (genvar e = 0; e < NUM_EP; e++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[e] <= '0;
      else if (wr_ok && cmd_q[7:4] == 4'h2 && idx == IDX_W'(e))
        cfg_q[e] <= wdata[CFG_W-1:0];
    end
    assign ep_cfg[e*CFG_W +: CFG_W] = cfg_q[e];
  end

  always_comb begin
    rdata = 16'h0000;
    if (rd_q && left_q != 2'd0) begin
      casez (cmd_q)
        8'h3?:   rdata = 16'(cfg_q[idx]);
        8'hA?:   rdata = 16'(ep_err_codes[int'(idx)*ERR_W +: ERR_W]);
        8'hB3:   rdata = scratch_q;
        8'hB4:   rdata = 16'(frame_num);
        8'hB5:   rdata = CHIP_ID;
        8'hC0:   rdata = irq_status[int'(W_IRQ - left_q)*16 +: 16];
        default: rdata = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/cmd_regif_chk.sv
module cmd_regif_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_wr,
  input logic        data_wr,
  input logic        data_rd,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic [1:0]  words_left,
  input logic        cmd_err,
  input logic        ack_setup,
  input logic        unlock_pulse,
  input logic        rd_q,
  input logic [7:0]  cmd_q
);
  a_r11_read_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && data_rd && rd_q && words_left != 2'd0) |=> words_left == $past(words_left) - 2'd1);

  a_r11_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left == 2'd0) |-> rdata == 16'h0000);

  a_r12_wrong_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && !data_rd && data_wr && rd_q) |=> $stable(words_left));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (words_left != 2'd0 && rd_q && cmd_q[7:4] == 4'h3) |-> rdata[15:8] == 8'h00);

  a_r8_ack_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    ack_setup |-> (words_left == 2'd0 && !cmd_err));

  a_r10_err_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> words_left == 2'd0);

  a_r9_unlock_single: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_pulse |=> !unlock_pulse);

  a_r13_irq_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[7:0] == 8'hC0) |=> words_left == 2'd2);
endmodule

bind cmd_regif cmd_regif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .data_rd(data_rd),
  .wdata(wdata), .rdata(rdata), .words_left(words_left), .cmd_err(cmd_err),
  .ack_setup(ack_setup), .unlock_pulse(unlock_pulse), .rd_q(rd_q), .cmd_q(cmd_q)
);

// File: tb/cmd_regif_bench.sv
module cmd_regif_bench;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         cmd_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
  logic [15:0]  wdata = '0, rdata, unlock_data;
  logic [1:0]   words_left;
  logic         cmd_err, ack_setup, unlock_pulse;
  logic [127:0] ep_err_codes = 128'h9F8E7D6C5B4A39281706F5E4D3C2B1A0;
  logic [10:0]  frame_num = 11'h5C3;
  logic [31:0]  irq_status = 32'hDEAD_4B21;
  logic [127:0] ep_cfg;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  cmd_regif u_cmd_regif (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr), .data_rd(data_rd),
    .wdata(wdata), .rdata(rdata), .words_left(words_left), .cmd_err(cmd_err),
    .ack_setup(ack_setup), .unlock_pulse(unlock_pulse), .unlock_data(unlock_data),
    .ep_err_codes(ep_err_codes), .frame_num(frame_num), .irq_status(irq_status),
    .ep_cfg(ep_cfg)
  );

  int         m_code = 0, m_left = 0;
  bit         m_rd = 0, m_err = 0, m_ack = 0, m_unl = 0;
  logic [15:0] m_ud = '0, m_scr = '0;
  logic [7:0]  m_cfg [16];

  initial foreach (m_cfg[i]) m_cfg[i] = 8'h00;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_code = 0; m_left = 0; m_rd = 0; m_err = 0; m_ack = 0; m_unl = 0;
      m_ud = '0; m_scr = '0;
      foreach (m_cfg[i]) m_cfg[i] = 8'h00;
    end else begin
      m_ack = 0; m_unl = 0;
      if (cmd_wr) begin
        m_code = int'(wdata[7:0]); m_err = 0; m_ack = (m_code == 'hF4);
        if (m_code >= 'h20 && m_code <= 'h2F)                         begin m_rd = 0; m_left = 1; end
        else if (m_code >= 'h30 && m_code <= 'h3F)                    begin m_rd = 1; m_left = 1; end
        else if (m_code >= 'hA0 && m_code <= 'hAF)                    begin m_rd = 1; m_left = 1; end
        else if (m_code == 'hB0 || m_code == 'hB2)                    begin m_rd = 0; m_left = 1; end
        else if (m_code == 'hB3 || m_code == 'hB4 || m_code == 'hB5)  begin m_rd = 1; m_left = 1; end
        else if (m_code == 'hC0)                                      begin m_rd = 1; m_left = 2; end
        else if (m_code == 'hF4)                                      m_left = 0;
        else begin m_left = 0; m_err = 1; end
      end else if (m_left > 0 && ((data_wr && !m_rd) || (data_rd && m_rd))) begin
        if (!m_rd) begin
          if (m_code >= 'h20 && m_code <= 'h2F) m_cfg[m_code - 'h20] = wdata[7:0];
          if (m_code == 'hB0) begin m_unl = 1; m_ud = wdata; end
          if (m_code == 'hB2) m_scr = wdata;
        end
        m_left = m_left - 1;
      end
    end
  end

  function automatic logic [15:0] exp_rd();
    if (m_left == 0 || !m_rd) return 16'h0000;
    if (m_code >= 'h30 && m_code <= 'h3F) return {8'h00, m_cfg[m_code - 'h30]};
    if (m_code >= 'hA0 && m_code <= 'hAF) return {8'h00, ep_err_codes[(m_code - 'hA0)*8 +: 8]};
    if (m_code == 'hB3) return m_scr;
    if (m_code == 'hB4) return {5'b0, frame_num};
    if (m_code == 'hB5) return 16'h5A31;
    if (m_code == 'hC0) return (m_left == 2) ? irq_status[15:0] : irq_status[31:16];
    return 16'h0000;
  endfunction

  task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [127:0] cfg_exp;
    for (int i = 0; i < 16; i++) cfg_exp[i*8 +: 8] = m_cfg[i];
    chk("rdata", 128'(rdata), 128'(exp_rd()));
    chk("words_left", 128'(words_left), 128'(m_left));
    chk("cmd_err", 128'(cmd_err), 128'(m_err));
    chk("ack_setup", 128'(ack_setup), 128'(m_ack));
    chk("unlock_pulse", 128'(unlock_pulse), 128'(m_unl));
    if (m_unl) chk("unlock_data", 128'(unlock_data), 128'(m_ud));
    chk("ep_cfg", ep_cfg, cfg_exp);
  endtask

  task automatic step(bit c, bit w, bit r, logic [15:0] d);
    cmd_wr = c; data_wr = w; data_rd = r; wdata = d;
    #1 compare_all();
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] c);   step(1, 0, 0, {8'h00, c}); endtask
  task automatic wr(logic [15:0] d);   step(0, 1, 0, d);          endtask
  task automatic rd();                 step(0, 0, 1, 16'h0);      endtask
  task automatic idle();               step(0, 0, 0, 16'h0);      endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired in %s", tag);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    tag = "R1"; idle(); idle();
    rst_n = 1'b1; idle();
    tag = "R2"; // config writes, upper byte nonzero
    for (int e = 0; e < 16; e++) begin cmd(8'(8'h20 + e)); wr(16'hAB00 | 16'(e * 17 + 3)); end
    tag = "R3"; // read banks 16 codes above write banks
    for (int e = 0; e < 16; e++) begin cmd(8'(8'h30 + e)); rd(); end
    tag = "R4";
    cmd(8'hA0); rd(); cmd(8'hA1); rd(); cmd(8'hA7); rd(); cmd(8'hAF); rd();
    tag = "R5";
    cmd(8'hB2); wr(16'hC3E7); cmd(8'hB3); rd();
    tag = "R6";
    cmd(8'hB4); rd(); frame_num = 11'h7FF; cmd(8'hB4); rd(); cmd(8'hB5); idle(); rd();
    tag = "R7";
    cmd(8'hC0); idle(); rd(); idle(); rd(); cmd(8'hC0); rd(); rd(); idle();
    tag = "R8";
    cmd(8'hF4); idle(); rd(); wr(16'h1111); idle();
    tag = "R9";
    cmd(8'hB0); wr(16'h1234); wr(16'h4321); idle();
    tag = "R10";
    cmd(8'h55); wr(16'h00FF); rd(); cmd(8'hB1); idle(); cmd(8'hB5); rd();
    tag = "R11";
    cmd(8'hB2); wr(16'h0F0F); wr(16'hFFFF); rd(); cmd(8'hB3); rd(); rd(); idle();
    tag = "R12";
    cmd(8'hB3); wr(16'h2222); rd(); cmd(8'h25); rd(); wr(16'h0099); idle();
    tag = "R13";
    cmd(8'hC0); rd(); cmd(8'h21); wr(16'h0077); cmd(8'hC0); cmd(8'hB5); rd();
    cmd(8'hB2); step(1, 1, 0, 16'h00B3); rd(); cmd(8'h36); rd(); idle();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule